// File: doc/BRIEF.md
# Serial Link Start-Up Sequencer

This block sits on the transmit side of a current-mode serial display link and brings the link from a dead, zero-current condition to streaming pixel data. It is clocked by the pixel clock. It watches three qualifiers: an active-low power-down pin, a flag that says the pixel clock is running, and the lock flag of the transmit PLL. From these it drives an encoded line state for the clock lane and for each data lane, a phase code, and an enable for the downstream data path.

When power is enabled and the pixel clock is present, the sequencer spends a bias-settle interval with every lane still off. It then plays a fixed pattern on the clock lane: logic low for 200 cycles, logic high for 20 cycles, and logic low again for 8 cycles. The far end uses this pattern to wake up and to trim its current sources. Last comes a hold-off of at least 600 cycles, with the data lanes parked at logic low while the PLL settles. Once that count is spent and the PLL reports lock, the link goes active. Dropping power-down, or losing the pixel clock, returns the link to OFF on the next clock from any point in the sequence.

The internal states are OFF, BIAS, CLK_LO_A, CLK_HI, CLK_LO_B, HOLDOFF and ACTIVE. BIAS through HOLDOFF together form the LINK-UP phase. The transitions are:
- OFF→BIAS (start)
- BIAS→CLK_LO_A (bias done)
- CLK_LO_A→CLK_HI
- CLK_HI→CLK_LO_B
- CLK_LO_B→HOLDOFF
- HOLDOFF→ACTIVE (count done and locked)
- any→OFF (abort)

Top module: `link_startup_seq`

## Requirements
- R1: Lane codes are 2 bits each: 00 off (no current), 01 logic low, 10 logic high, 11 active clock or data. Phase codes are 00 OFF, 01 LINK-UP and 10 ACTIVE. In OFF, and directly after reset, every lane reads 00, the phase reads 00 and data_en is 0.
- R2: The block stays in OFF for as long as pd_n is 0 or pclk_ok is 0.
- R3: The clock edge that sees pd_n=1 and pclk_ok=1 in OFF starts LINK-UP, whichever of the two came last. For the first BIAS_CYC cycles (default 16) all lanes stay 00 while the phase reads 01.
- R4: The clock lane then reads 01 for exactly 200 cycles, with the data lanes at 00.
- R5: The clock lane then reads 10 for exactly 20 cycles, with the data lanes at 00.
- R6: The clock lane then reads 01 for exactly 8 cycles, with the data lanes at 00.
- R7: During the hold-off, which lasts at least 600 cycles, the clock lane and every data lane read 01 and the phase reads 01.
- R8: ACTIVE is entered only from LINK-UP, only after the full hold-off count, and only on an edge where pll_lock is 1. If lock is absent when the count ends, the hold-off is extended until lock arrives.
- R9: In ACTIVE the clock lane and every data lane read 11, the phase reads 10 and data_en is 1.
- R10: pd_n at 0 in any phase puts the block in OFF on the next clock. A later restart replays the whole sequence from the start of the bias interval.
- R11: pclk_ok at 0 in any phase puts the block in OFF on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down, active low |
| pclk_ok | input | 1 | Pixel clock present |
| pll_lock | input | 1 | Transmit PLL lock flag |
| clk_lane | output | 2 | Clock lane line-state code |
| data_lane | output | 2*N_LANES | Line-state code per data lane, lane 0 in the low bits |
| link_phase | output | 2 | Link phase code |
| data_en | output | 1 | Data path enable, high in ACTIVE only |

## Verification
The checker tests a set of rules on every cycle:
- the abort rules for power-down and for loss of the pixel clock;
- the all-off lane pattern while in OFF;
- the lane pattern in ACTIVE;
- that ACTIVE is entered only from LINK-UP with lock present;
- through its own run counter, that every high pulse on the clock lane lasts exactly 20 cycles.

Other behaviour can only be shown by the bench's scenarios:
- the exact first and last cycle of each low, high and hold-off segment;
- the extension of the hold-off when lock arrives late;
- a start caused by the pixel clock arriving after power-down was already released;
- a restart from scratch after an abort.

// File: rtl/link_startup_pkg.sv
package link_startup_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_BIAS,
        ST_CLK_LO_A,
        ST_CLK_HI,
        ST_CLK_LO_B,
        ST_HOLDOFF,
        ST_ACTIVE
    } seq_state_t;

    typedef logic [1:0] lane_code_t;

    localparam lane_code_t LANE_OFF  = 2'b00;
    localparam lane_code_t LANE_LOW  = 2'b01;
    localparam lane_code_t LANE_HIGH = 2'b10;
    localparam lane_code_t LANE_ACT  = 2'b11;

    typedef logic [1:0] phase_code_t;

    localparam phase_code_t PH_OFF    = 2'b00;
    localparam phase_code_t PH_LINKUP = 2'b01;
    localparam phase_code_t PH_ACTIVE = 2'b10;

    typedef struct packed {
        lane_code_t  clk_code;
        lane_code_t  data_code;
        phase_code_t phase;
        logic        data_en;
    } seq_out_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/link_phase_timer.sv
module link_phase_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Counts cycles spent in the current segment; saturates so that an
    // extended hold-off waiting for lock cannot wrap back to zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/link_startup_fsm.sv
module link_startup_fsm
    import link_startup_pkg::*;
#(
    parameter int BIAS_CYC = 16,
    parameter int LO_A_CYC = 200,
    parameter int HI_CYC   = 20,
    parameter int LO_B_CYC = 8,
    parameter int HOLD_CYC = 600,
    parameter int CNT_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             pclk_ok,
    input  logic             pll_lock,
    input  logic [CNT_W-1:0] seg_count,
    output logic             seg_clear,
    output seq_out_t         seq_out
);

    localparam logic [CNT_W-1:0] BIAS_LAST = CNT_W'(BIAS_CYC - 1);
    localparam logic [CNT_W-1:0] LO_A_LAST = CNT_W'(LO_A_CYC - 1);
    localparam logic [CNT_W-1:0] HI_LAST   = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] LO_B_LAST = CNT_W'(LO_B_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       link_ok;

    assign link_ok = pd_n && pclk_ok;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        if (!link_ok) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:      state_d = ST_BIAS;
                ST_BIAS:     if (seg_count == BIAS_LAST) state_d = ST_CLK_LO_A;
                ST_CLK_LO_A: if (seg_count == LO_A_LAST) state_d = ST_CLK_HI;
                ST_CLK_HI:   if (seg_count == HI_LAST)   state_d = ST_CLK_LO_B;
                ST_CLK_LO_B: if (seg_count == LO_B_LAST) state_d = ST_HOLDOFF;
                ST_HOLDOFF:  if ((seg_count >= HOLD_LAST) && pll_lock) state_d = ST_ACTIVE;
                ST_ACTIVE:   state_d = ST_ACTIVE;
                default:     state_d = ST_OFF;
            endcase
        end
    end

    // The segment counter restarts on every change of state, including aborts.
    assign seg_clear = (state_d != state_q) || (state_q == ST_OFF);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        seq_out = '{clk_code: LANE_OFF, data_code: LANE_OFF, phase: PH_OFF, data_en: 1'b0};
        unique case (state_q)
            ST_OFF: begin
                seq_out.phase = PH_OFF;
            end
            ST_BIAS: begin
                seq_out.phase = PH_LINKUP;
            end
            ST_CLK_LO_A, ST_CLK_LO_B: begin
                seq_out.phase    = PH_LINKUP;
                seq_out.clk_code = LANE_LOW;
            end
            ST_CLK_HI: begin
                seq_out.phase    = PH_LINKUP;
                seq_out.clk_code = LANE_HIGH;
            end
            ST_HOLDOFF: begin
                seq_out.phase     = PH_LINKUP;
                seq_out.clk_code  = LANE_LOW;
                seq_out.data_code = LANE_LOW;
            end
            ST_ACTIVE: begin
                seq_out.phase     = PH_ACTIVE;
                seq_out.clk_code  = LANE_ACT;
                seq_out.data_code = LANE_ACT;
                seq_out.data_en   = 1'b1;
            end
            default: begin
                seq_out.phase = PH_OFF;
            end
        endcase
    end

endmodule

// File: rtl/link_lane_drive.sv
module link_lane_drive
    import link_startup_pkg::*;
#(
    parameter int N_LANES = 2
) (
    input  lane_code_t               clk_code,
    input  lane_code_t               data_code,
    output logic [1:0]               clk_lane,
    output logic [2*N_LANES-1:0]     data_lane
);

    assign clk_lane = clk_code;

    // Every data lane follows the same line state through start-up.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign data_lane[2*g +: 2] = data_code;
    end

endmodule

// File: rtl/link_startup_seq.sv
module link_startup_seq
    import link_startup_pkg::*;
#(
    parameter int N_LANES  = 2,
    parameter int BIAS_CYC = 16,
    parameter int LO_A_CYC = 200,
    parameter int HI_CYC   = 20,
    parameter int LO_B_CYC = 8,
    parameter int HOLD_CYC = 600
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pd_n,
    input  logic                 pclk_ok,
    input  logic                 pll_lock,
    output logic [1:0]           clk_lane,
    output logic [2*N_LANES-1:0] data_lane,
    output logic [1:0]           link_phase,
    output logic                 data_en
);

    localparam int LONGEST = max_of(max_of(max_of(BIAS_CYC, LO_A_CYC),
                                           max_of(HI_CYC, LO_B_CYC)), HOLD_CYC);
    localparam int CNT_W   = $clog2(LONGEST + 1);

    logic [CNT_W-1:0] seg_count;
    logic             seg_clear;
    seq_out_t         seq_out;

    link_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (seg_clear),
        .count (seg_count)
    );

    link_startup_fsm #(
        .BIAS_CYC (BIAS_CYC),
        .LO_A_CYC (LO_A_CYC),
        .HI_CYC   (HI_CYC),
        .LO_B_CYC (LO_B_CYC),
        .HOLD_CYC (HOLD_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_n      (pd_n),
        .pclk_ok   (pclk_ok),
        .pll_lock  (pll_lock),
        .seg_count (seg_count),
        .seg_clear (seg_clear),
        .seq_out   (seq_out)
    );

    link_lane_drive #(
        .N_LANES (N_LANES)
    ) u_drive (
        .clk_code  (seq_out.clk_code),
        .data_code (seq_out.data_code),
        .clk_lane  (clk_lane),
        .data_lane (data_lane)
    );

    assign link_phase = seq_out.phase;
    assign data_en    = seq_out.data_en;

endmodule

// File: rtl/link_startup_chk.sv
module link_startup_chk #(
    parameter int N_LANES = 2,
    parameter int HI_CYC  = 20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pd_n,
    input logic                 pclk_ok,
    input logic                 pll_lock,
    input logic [1:0]           clk_lane,
    input logic [2*N_LANES-1:0] data_lane,
    input logic [1:0]           link_phase,
    input logic                 data_en
);

    logic [15:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (clk_lane == 2'b10) begin
            hi_run <= hi_run + 16'd1;
        end else begin
            hi_run <= '0;
        end
    end

    p_off_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (link_phase == 2'b00) |-> (clk_lane == 2'b00 && data_lane == '0 && !data_en));

    p_pd_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (link_phase == 2'b00));

    p_pclk_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pclk_ok |=> (link_phase == 2'b00));

    p_active_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_phase == 2'b10) |-> (clk_lane == 2'b11 && data_lane == {N_LANES{2'b11}} && data_en));

    p_enter_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_phase == 2'b10 && $past(link_phase) != 2'b10) |-> $past(pll_lock));

    p_enter_from_linkup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_phase == 2'b10 && $past(link_phase) != 2'b10) |-> ($past(link_phase) == 2'b01));

    p_high_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_lane == 2'b01 && hi_run != 16'd0) |-> (hi_run == 16'(HI_CYC)));

endmodule

bind link_startup_seq link_startup_chk #(
    .N_LANES (N_LANES),
    .HI_CYC  (HI_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_n       (pd_n),
    .pclk_ok    (pclk_ok),
    .pll_lock   (pll_lock),
    .clk_lane   (clk_lane),
    .data_lane  (data_lane),
    .link_phase (link_phase),
    .data_en    (data_en)
);

// File: tb/sim_link_startup_seq.sv
`timescale 1ns/1ps
module sim_link_startup_seq;

    localparam int NL = 2;
    localparam int NV = 12;

    // Columns: edges since start, phase, clock-lane code, data-lane code, data_en.
    localparam int VEC [NV][5] = '{
        '{  1, 1, 0, 0, 0},   // R3 first bias cycle
        '{ 16, 1, 0, 0, 0},   // R3 last bias cycle
        '{ 17, 1, 1, 0, 0},   // R4 first low
        '{216, 1, 1, 0, 0},   // R4 last low
        '{217, 1, 2, 0, 0},   // R5 first high
        '{236, 1, 2, 0, 0},   // R5 last high
        '{237, 1, 1, 0, 0},   // R6 first low
        '{244, 1, 1, 0, 0},   // R6 last low
        '{245, 1, 1, 1, 0},   // R7 first hold-off
        '{844, 1, 1, 1, 0},   // R7 last hold-off
        '{845, 2, 3, 3, 1},   // R9 active
        '{900, 2, 3, 3, 1}    // R9 stays active
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pd_n = 1'b0;
    logic            pclk_ok = 1'b0;
    logic            pll_lock = 1'b0;
    logic [1:0]      clk_lane;
    logic [2*NL-1:0] data_lane;
    logic [1:0]      link_phase;
    logic            data_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    link_startup_seq #(.N_LANES(NL)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_n       (pd_n),
        .pclk_ok    (pclk_ok),
        .pll_lock   (pll_lock),
        .clk_lane   (clk_lane),
        .data_lane  (data_lane),
        .link_phase (link_phase),
        .data_en    (data_en)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4, 5:    return "R5";
            6, 7:    return "R6";
            8, 9:    return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_state(input string tag, input int ph, input int ck,
                                input int dc, input int en);
        logic [2*NL-1:0] exp_d;
        exp_d = {NL{2'(dc)}};
        n_checks++;
        if (link_phase !== 2'(ph) || clk_lane !== 2'(ck) ||
            data_lane !== exp_d || data_en !== 1'(en)) begin
            n_fail++;
            $display("FAIL %s: phase=%0d clk=%0d data=%0h en=%0d expected phase=%0d clk=%0d data=%0h en=%0d",
                     tag, link_phase, clk_lane, data_lane, data_en, ph, ck, exp_d, en);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int vi;
        repeat (3) step();
        // R1: reset state
        expect_state("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        step();
        expect_state("R1", 0, 0, 0, 0);

        // Table walk: lock already present, power and clock enabled together.
        pll_lock = 1'b1;
        pd_n     = 1'b1;
        pclk_ok  = 1'b1;
        vi = 0;
        for (int n = 1; n <= 900; n++) begin
            step();
            if (vi < NV && n == VEC[vi][0]) begin
                expect_state(vec_tag(vi), VEC[vi][1], VEC[vi][2], VEC[vi][3], VEC[vi][4]);
                vi++;
            end
        end

        // R10: power-down from ACTIVE
        pd_n = 1'b0;
        step();
        expect_state("R10", 0, 0, 0, 0);

        // R2: pixel clock absent with power released keeps OFF
        pclk_ok = 1'b0;
        pd_n    = 1'b1;
        repeat (10) step();
        expect_state("R2", 0, 0, 0, 0);

        // R3: pixel clock arrives after power-down released
        pclk_ok = 1'b1;
        step();
        expect_state("R3", 1, 0, 0, 0);

        // R11: loss of the pixel clock during the high pulse
        for (int n = 2; n <= 220; n++) step();
        expect_state("R5", 1, 2, 0, 0);
        pclk_ok = 1'b0;
        step();
        expect_state("R11", 0, 0, 0, 0);

        // R10: abort during first low, then restart from scratch
        pclk_ok = 1'b1;
        for (int n = 1; n <= 100; n++) step();
        expect_state("R4", 1, 1, 0, 0);
        pd_n = 1'b0;
        step();
        expect_state("R10", 0, 0, 0, 0);
        pd_n = 1'b1;
        for (int n = 1; n <= 16; n++) step();
        expect_state("R10", 1, 0, 0, 0);
        step();
        expect_state("R10", 1, 1, 0, 0);

        // R8: lock absent at end of hold-off extends it
        pll_lock = 1'b0;
        for (int n = 18; n <= 900; n++) step();
        expect_state("R8", 1, 1, 1, 0);
        pll_lock = 1'b1;
        step();
        expect_state("R8", 2, 3, 3, 1);

        // R2: power-down held low keeps OFF regardless of clock
        pd_n = 1'b0;
        step();
        repeat (5) step();
        expect_state("R2", 0, 0, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule